// File: doc/BRIEF.md
# Time-Shared Multi-Channel Gold Sequence Generator

This block produces many independent Gold sequences from one pair of linear feedback update circuits. The state of every channel lives in a small on-chip memory rather than in flip-flops. Each clock the block visits one channel slot. It reads that slot's two 25-bit register states, emits the two code bits for the current chip, advances both registers by one chip and writes them back to the same address. Slots are visited round-robin, so with N slots every channel produces one chip every N cycles. With 32 slots at 3.84 Mchip/s per channel, the clock must run at 122.88 MHz.

The first register follows the feedback polynomial x^25 + x^3 + 1. The second follows x^25 + x^3 + x^2 + x + 1. They are held in two separate memories. Each memory holds several banks of N states. A bank selector picks which set of channels runs, and a change to it takes effect only when the slot pointer wraps. A host seed port writes new initial states into any bank and slot. It shares the memory write port with the write-back path, and it stalls the generator while it is active. A stop input also halts the generator, and a status output reports the halt.

Top module: `tdm_gold_gen`

## Requirements
- R1: Slots are visited in increasing order from 0 to NUM_SLOTS-1 and then wrap to 0. Each valid output carries its slot index on `out_slot`, and every visit produces exactly one valid output.
- R2: State bit k is the register element k chips ahead of the current one. `code_i` equals bit 0 of the first state XOR bit 0 of the second state, both taken before the advance.
- R3: `code_q` equals the XOR of first-state bits 4, 7 and 18 with second-state bits 4, 6 and 17, all taken before the advance.
- R4: Each visit advances both states by one chip. Every bit k moves to k-1. The new bit 24 of the first state is bit0 XOR bit3. The new bit 24 of the second state is bit0 XOR bit1 XOR bit2 XOR bit3.
- R5: `round_end` is high exactly on the valid output of slot NUM_SLOTS-1 and is low otherwise.
- R6: After reset the active bank is 0. `bank_sel` is sampled only when the pointer wraps from the last slot to slot 0. All outputs of one round come from one bank, which `out_bank` reports.
- R7: While `stop` is high, no slot advances and no output is valid. `stopped` is high from the cycle after `stop` rises. After release the round continues at the slot where it halted, with no slot skipped or advanced twice.
- R8: A host write loads `host_x` and `host_y` into the slot `host_slot` of the bank `host_bank`, and it takes priority on the write port. In the cycle after the write, `stopped` is high and `out_valid` is low. A write-back displaced by the host write is redone later, so channel sequences stay intact, and the next visit to the written slot starts from the new seed.
- R9: While reset is held, `out_valid`, `round_end`, `code_i` and `code_q` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stop | input | 1 | Halts the generator while high |
| bank_sel | input | BANK_W | Requested bank for the next round |
| host_we | input | 1 | Seed write strobe |
| host_bank | input | BANK_W | Seed write bank |
| host_slot | input | SLOT_W | Seed write slot |
| host_x | input | 25 | Seed for the first register |
| host_y | input | 25 | Seed for the second register |
| code_i | output | 1 | In-phase code bit of the emitted slot |
| code_q | output | 1 | Quadrature code bit of the emitted slot |
| out_valid | output | 1 | Code bits and tags are valid |
| out_slot | output | SLOT_W | Slot of the emitted bits |
| out_bank | output | BANK_W | Bank of the emitted bits |
| round_end | output | 1 | Last slot of a round emitted |
| stopped | output | 1 | Generator halted in the previous cycle |

## Verification
The bench builds the block with its defaults: 32 slots, 4 banks and 25-bit states. A full round therefore has 32 visits, and each slot's memory address is the bank index joined to the slot index. Over five rounds it covers every bank switch at the wrap, one bank run for two consecutive rounds, a stop in the middle of a round, and a host write to an idle bank while a write-back is in flight. That write-back is displaced and has to be redone, and the new seed must surface when its bank becomes active.

// File: rtl/gold_tdm_pkg.sv
package gold_tdm_pkg;
    localparam int STATE_W = 25;

    // feedback taps: first register bits 0,3; second register bits 0..3
    localparam logic [STATE_W-1:0] X_FB_TAPS = 25'h000_0009;
    localparam logic [STATE_W-1:0] Y_FB_TAPS = 25'h000_000F;
    // quadrature taps: first register bits 4,7,18; second bits 4,6,17
    localparam logic [STATE_W-1:0] X_Q_TAPS  = 25'h004_0090;
    localparam logic [STATE_W-1:0] Y_Q_TAPS  = 25'h002_0050;

    typedef logic [STATE_W-1:0] lfsr_state_t;
endpackage

// File: rtl/gold_state_ram.sv
module gold_state_ram #(
    parameter int WIDTH  = 25,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/gold_lfsr_step.sv
module gold_lfsr_step
    import gold_tdm_pkg::*;
(
    input  lfsr_state_t x_cur,
    input  lfsr_state_t y_cur,
    output lfsr_state_t x_next,
    output lfsr_state_t y_next,
    output logic        bit_i,
    output logic        bit_q
);
    always_comb begin
        x_next = {^(x_cur & X_FB_TAPS), x_cur[STATE_W-1:1]};
        y_next = {^(y_cur & Y_FB_TAPS), y_cur[STATE_W-1:1]};
        bit_i  = x_cur[0] ^ y_cur[0];
        bit_q  = (^(x_cur & X_Q_TAPS)) ^ (^(y_cur & Y_Q_TAPS));
    end
endmodule

// File: rtl/gold_slot_sched.sv
module gold_slot_sched #(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_BANKS = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              rewind,
    input  logic [SLOT_W-1:0] rw_slot,
    input  logic [BANK_W-1:0] rw_bank,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [SLOT_W-1:0] slot,
    output logic [BANK_W-1:0] bank
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BANK_W-1:0] bank;
    } sched_t;

    sched_t sch_d, sch_q;

    always_comb begin
        sch_d = sch_q;
        if (rewind) begin
            sch_d.slot = rw_slot;
            sch_d.bank = rw_bank;
        end else if (advance) begin
            if (sch_q.slot == LAST) begin
                sch_d.slot = '0;
                sch_d.bank = bank_sel;
            end else begin
                sch_d.slot = sch_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sch_q <= '0;
        else     sch_q <= sch_d;
    end

    assign slot = sch_q.slot;
    assign bank = sch_q.bank;

    // R1
    slot_order_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !rewind && slot != LAST) |=> (slot == $past(slot) + 1'b1));

    // R6
    bank_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!rewind && !(advance && slot == LAST)) |=> $stable(bank));
endmodule

// File: rtl/tdm_gold_gen.sv
module tdm_gold_gen
    import gold_tdm_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_BANKS = 4,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              host_we,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [SLOT_W-1:0] host_slot,
    input  logic [24:0]       host_x,
    input  logic [24:0]       host_y,
    output logic              code_i,
    output logic              code_q,
    output logic              out_valid,
    output logic [SLOT_W-1:0] out_slot,
    output logic [BANK_W-1:0] out_bank,
    output logic              round_end,
    output logic              stopped
);
    localparam int ADDR_W = SLOT_W + BANK_W;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic              s1_vld;
        logic [SLOT_W-1:0] s1_slot;
        logic [BANK_W-1:0] s1_bank;
        logic              o_vld;
        logic [SLOT_W-1:0] o_slot;
        logic [BANK_W-1:0] o_bank;
        logic              o_ci;
        logic              o_cq;
        logic              o_round;
        logic              stopped;
    } pipe_t;

    pipe_t p_d, p_q;

    logic              run_en;
    logic              kill_wb;
    logic [SLOT_W-1:0] rd_slot;
    logic [BANK_W-1:0] rd_bank;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    lfsr_state_t       x_cur, y_cur, x_nxt, y_nxt;
    lfsr_state_t       x_wdata, y_wdata;
    logic              bit_i, bit_q;

    assign run_en  = !stop && !host_we;
    assign kill_wb = p_q.s1_vld && host_we;

    gold_slot_sched #(
        .NUM_SLOTS(NUM_SLOTS),
        .NUM_BANKS(NUM_BANKS)
    ) i_sched (
        .clk     (clk),
        .rst     (rst),
        .advance (run_en),
        .rewind  (kill_wb),
        .rw_slot (p_q.s1_slot),
        .rw_bank (p_q.s1_bank),
        .bank_sel(bank_sel),
        .slot    (rd_slot),
        .bank    (rd_bank)
    );

    // write-port select: host seed beats the write-back
    always_comb begin
        ram_we = host_we || p_q.s1_vld;
        if (host_we) begin
            ram_waddr = {host_bank, host_slot};
            x_wdata   = host_x;
            y_wdata   = host_y;
        end else begin
            ram_waddr = {p_q.s1_bank, p_q.s1_slot};
            x_wdata   = x_nxt;
            y_wdata   = y_nxt;
        end
    end

    gold_state_ram #(.WIDTH(STATE_W), .ADDR_W(ADDR_W)) i_ram_x (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(x_wdata),
        .raddr({rd_bank, rd_slot}),
        .rdata(x_cur)
    );

    gold_state_ram #(.WIDTH(STATE_W), .ADDR_W(ADDR_W)) i_ram_y (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(y_wdata),
        .raddr({rd_bank, rd_slot}),
        .rdata(y_cur)
    );

    gold_lfsr_step i_step (
        .x_cur (x_cur),
        .y_cur (y_cur),
        .x_next(x_nxt),
        .y_next(y_nxt),
        .bit_i (bit_i),
        .bit_q (bit_q)
    );

    always_comb begin
        p_d         = p_q;
        p_d.s1_vld  = run_en;
        p_d.s1_slot = rd_slot;
        p_d.s1_bank = rd_bank;
        p_d.o_vld   = p_q.s1_vld && !host_we;
        p_d.o_slot  = p_q.s1_slot;
        p_d.o_bank  = p_q.s1_bank;
        p_d.o_ci    = p_d.o_vld && bit_i;
        p_d.o_cq    = p_d.o_vld && bit_q;
        p_d.o_round = p_d.o_vld && (p_q.s1_slot == LAST);
        p_d.stopped = !run_en;
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign code_i    = p_q.o_ci;
    assign code_q    = p_q.o_cq;
    assign out_valid = p_q.o_vld;
    assign out_slot  = p_q.o_slot;
    assign out_bank  = p_q.o_bank;
    assign round_end = p_q.o_round;
    assign stopped   = p_q.stopped;

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stopped && $past(stopped)) |-> !out_valid);

    // R8
    host_stall_chk: assert property (@(posedge clk) disable iff (rst)
        host_we |=> (stopped && !out_valid));

    // R6
    round_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && out_slot != '0) |-> (out_bank == $past(out_bank)));

    // R5
    round_flag_chk: assert property (@(posedge clk) disable iff (rst)
        round_end |-> (out_valid && out_slot == LAST));
endmodule

// File: tb/test_tdm_gold_gen.sv
module test_tdm_gold_gen;
    localparam int NS = 32;
    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop = 1'b1;
    logic [1:0]  bank_sel = '0;
    logic        host_we = 1'b0;
    logic [1:0]  host_bank = '0;
    logic [4:0]  host_slot = '0;
    logic [24:0] host_x = '0;
    logic [24:0] host_y = '0;
    logic        code_i, code_q, out_valid, round_end, stopped;
    logic [4:0]  out_slot;
    logic [1:0]  out_bank;

    always #2 clk = ~clk;

    tdm_gold_gen i_tdm_gold_gen (
        .clk(clk), .rst(rst), .stop(stop), .bank_sel(bank_sel),
        .host_we(host_we), .host_bank(host_bank), .host_slot(host_slot),
        .host_x(host_x), .host_y(host_y),
        .code_i(code_i), .code_q(code_q), .out_valid(out_valid),
        .out_slot(out_slot), .out_bank(out_bank),
        .round_end(round_end), .stopped(stopped)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_out   = 0;
    bit done    = 1'b0;
    int exp_q[$];

    logic [24:0] mx [NB][NS];
    logic [24:0] my [NB][NS];
    bit          seen    [NB][NS];
    bit          touched [NB][NS];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [24:0] adv_x(input logic [24:0] s);
        return {s[0] ^ s[3], s[24:1]};
    endfunction

    function automatic logic [24:0] adv_y(input logic [24:0] s);
        return {s[0] ^ s[1] ^ s[2] ^ s[3], s[24:1]};
    endfunction

    task automatic push_round(input int b);
        for (int s = 0; s < NS; s++) exp_q.push_back(b * NS + s);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && round_end && !out_valid)
            chk(1'b0, "R5", "round_end without valid", 1, 0);
        if (!rst && out_valid) begin
            n_out++;
            if (exp_q.size() > 0) begin
                int e, b, s;
                logic ei, eq;
                string tag;
                e = exp_q.pop_front();
                b = e / NS;
                s = e % NS;
                chk(out_slot == 5'(s), "R1", "slot order", out_slot, s);
                chk(out_bank == 2'(b), "R6", "bank", out_bank, b);
                chk(round_end == (s == NS - 1), "R5", "round_end", round_end, s == NS - 1);
                ei = mx[b][s][0] ^ my[b][s][0];
                eq = mx[b][s][4] ^ mx[b][s][7] ^ mx[b][s][18]
                   ^ my[b][s][4] ^ my[b][s][6] ^ my[b][s][17];
                if (touched[b][s])   tag = "R8";
                else if (seen[b][s]) tag = "R4";
                else                 tag = "R2";
                chk(code_i == ei, tag, "code_i", code_i, ei);
                chk(code_q == eq, (tag == "R2") ? "R3" : tag, "code_q", code_q, eq);
                touched[b][s] = 1'b0;
                seen[b][s]    = 1'b1;
                mx[b][s] = adv_x(mx[b][s]);
                my[b][s] = adv_y(my[b][s]);
            end
        end
    end

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", n_out, 160);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
        chk(round_end == 1'b0, "R9", "round_end in reset", round_end, 0);
        chk(code_i == 1'b0 && code_q == 1'b0, "R9", "codes in reset",
            {code_i, code_q}, 0);
        rst = 1'b0;

        // seed every bank/slot while halted
        for (int b = 0; b < NB; b++) begin
            for (int s = 0; s < NS; s++) begin
                logic [24:0] sx, sy;
                sx = 25'((b * NS + s + 1) * 32'h00B5_A3C1);
                sy = 25'((b * NS + s + 7) * 32'h0127_4D95) ^ 25'h155_5555;
                host_we = 1'b1; host_bank = 2'(b); host_slot = 5'(s);
                host_x = sx; host_y = sy;
                mx[b][s] = sx; my[b][s] = sy;
                @(negedge clk);
            end
        end
        host_we = 1'b0;
        @(negedge clk);
        chk(stopped == 1'b1, "R7", "stopped while held", stopped, 1);
        chk(out_valid == 1'b0, "R7", "no output while held", out_valid, 0);

        push_round(0); push_round(2); push_round(2); push_round(3); push_round(1);
        stop = 1'b0;
        bank_sel = 2'd2;

        // mid-round stop in second bank-2 round
        wait (n_out >= 74);
        @(negedge clk);
        stop = 1'b1;
        bank_sel = 2'd3;
        repeat (3) @(negedge clk);
        chk(stopped == 1'b1, "R7", "stopped flag", stopped, 1);
        chk(out_valid == 1'b0, "R7", "valid during stop", out_valid, 0);
        begin
            int held;
            held = n_out;
            repeat (4) @(negedge clk);
            chk(n_out == held, "R7", "outputs during stop", n_out, held);
        end
        stop = 1'b0;

        // host write into idle bank 1 while bank 3 runs
        wait (n_out >= 104);
        @(negedge clk);
        host_we = 1'b1; host_bank = 2'd1; host_slot = 5'd5;
        host_x = 25'h0AB_CDEF; host_y = 25'h13_5791;
        mx[1][5] = 25'h0AB_CDEF; my[1][5] = 25'h13_5791;
        touched[1][5] = 1'b1;
        @(negedge clk);
        chk(stopped == 1'b1, "R8", "stall on host write", stopped, 1);
        chk(out_valid == 1'b0, "R8", "valid on host write", out_valid, 0);
        host_we = 1'b0;
        bank_sel = 2'd1;

        wait (n_out >= 5 * NS);
        @(negedge clk);
        stop = 1'b1;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1", "items left", exp_q.size(), 0);
        chk(touched[1][5] == 1'b0, "R8", "reseeded slot visited", touched[1][5], 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule